// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block generates the clocking for reading a CCD once its exposure has finished. A single start pulse launches a full frame readout. Each row group begins with parallel transfers that move charge into the serial register. Serial shifts then carry each column toward the output amplifier. Every pixel that is kept gets a reset-level sample, a signal-level sample and a converter start. Every other pixel is shifted while the drain control is held high, so its charge is thrown away and nothing is sampled.

Several features change the pixel flow:
- Vertical binning sums several rows in the serial register before any serial shifting.
- Horizontal binning sums several columns on the sense node before a single sample.
- A column window keeps only a range of columns.
- Overscan shifts at the end of each row measure the bias level.

Each transfer is a three-phase pattern. The length of each phase step is programmable. The block produces only timing. The analog chain, the converter data and the frame storage belong to other blocks.

Top module: `ccd_readout_seq`

## Requirements
- R1: A start pulse seen while the sequencer is idle captures every configuration input and raises `busy`. A start pulse, or a change of any configuration input, while `busy` is high has no effect on the readout in progress.
- R2: Each row group begins with exactly VB parallel transfers issued back to back, with no serial shift between them. VB is the vertical bin factor, and a bin value of 0 is treated as 1. If fewer than VB unread rows remain, those rows are not transferred and the readout ends.
- R3: A transfer drives its phase bits high one at a time, in the order bit 0, bit 1, bit 2. Each bit stays high for `cfg_step` cycles, and a step of 0 is treated as 1. At most one parallel bit and at most one serial bit is high at any time. Parallel and serial phases are never high together.
- R4: After the parallel transfers of a row group, exactly `cfg_cols + cfg_overscan` serial shifts are issued before the next parallel transfer.
- R5: A real column below `cfg_win_first` or above the window end is shifted with `dump` high for the whole shift. It produces no `smp_rst`, `smp_sig`, `adc_start` or `pix_valid`.
- R6: A window end at or beyond `cfg_cols` is clipped to column `cfg_cols-1`. A window whose first column lies past its clipped end keeps no real columns.
- R7: Window columns are grouped by HB from the window start, where HB is the horizontal bin factor and 0 is treated as 1. Each complete group is shifted with `dump` low, and its last shift is followed by exactly one sample sequence. A final group of fewer than HB window columns is shifted with `dump` high.
- R8: Each overscan shift is taken with `dump` low and is followed by its own sample sequence, whatever the value of HB.
- R9: A sample sequence is `smp_rst` for one cycle, then `smp_sig` for one cycle, then `adc_start` and `pix_valid` together for one cycle, in consecutive cycles.
- R10: After the last row group, `done` is high for one cycle and `busy` falls in the next cycle. The number of `pix_valid` pulses in a readout is floor(rows/VB) × (floor(W/HB) + overscan), where W is the number of columns in the clipped window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a readout (accepted only while idle) |
| cfg_rows | input | ROW_W | Rows in the frame |
| cfg_cols | input | COL_W | Real columns per row |
| cfg_overscan | input | OS_W | Overscan shifts per row |
| cfg_vbin | input | BIN_W | Vertical bin factor |
| cfg_hbin | input | BIN_W | Horizontal bin factor |
| cfg_win_first | input | COL_W | First kept column |
| cfg_win_last | input | COL_W | Last kept column (inclusive) |
| cfg_step | input | STEP_W | Cycles per phase step |
| par_clk | output | NPH | Parallel phase clocks |
| ser_clk | output | NPH | Serial phase clocks |
| dump | output | 1 | Drain the pixel being shifted |
| smp_rst | output | 1 | Reset-level sample strobe |
| smp_sig | output | 1 | Signal-level sample strobe |
| adc_start | output | 1 | Converter start pulse |
| pix_valid | output | 1 | A binned pixel has been sampled |
| busy | output | 1 | Readout in progress |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The hardest case to reach is the partial bin group at the far edge of the window. It needs a window width that is not a multiple of the horizontal bin factor, sometimes also clipped against the row length. Combined with leftover rows under vertical binning, it shows in only a few shifts per row. The bench sweeps window start, window end, both bin factors and the overscan count over a six-column frame. For every shift it computes whether the column should be drained or kept. It then compares that with `dump` at the first phase edge of each shift. Separate runs cover bin values of zero, an empty window, zero rows, longer phase steps, and a start pulse with new configuration sent in the middle of a readout.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PAR_GO,
      S_PAR_WAIT,
      S_SER_GO,
      S_SER_WAIT,
      S_SHR,
      S_SHS,
      S_CONV,
      S_DONE
   } seq_state_t;

   typedef struct packed {
      logic dump;    // drain this shift
      logic sample;  // run a sample sequence after this shift
      logic binned;  // shift belongs to a kept window group
   } col_act_t;

endpackage

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen #(
   parameter int NPH    = 3,
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [STEP_W-1:0] step_len,
   output logic [NPH-1:0]    ph,
   output logic              fin
);
   localparam int IDX_W = (NPH > 1) ? $clog2(NPH) : 1;

   if (NPH < 2) begin : g_bad_nph
      $error("ccd_phase_gen: NPH must be at least 2");
   end

   logic              active_q;
   logic              fin_q;
   logic [IDX_W-1:0]  idx_q;
   logic [STEP_W-1:0] cnt_q;
   logic [STEP_W-1:0] len_m1;

   assign len_m1 = (step_len == '0) ? '0 : step_len - STEP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         fin_q    <= 1'b0;
         idx_q    <= '0;
         cnt_q    <= '0;
      end else begin
         fin_q <= 1'b0;
         if (!active_q) begin
            if (go) begin
               active_q <= 1'b1;
               idx_q    <= '0;
               cnt_q    <= '0;
            end
         end else if (cnt_q == len_m1) begin
            cnt_q <= '0;
            if (idx_q == IDX_W'(NPH - 1)) begin
               active_q <= 1'b0;
               fin_q    <= 1'b1;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end else begin
            cnt_q <= cnt_q + STEP_W'(1);
         end
      end
   end

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      assign ph[p] = active_q && (idx_q == IDX_W'(p));
   end

   assign fin = fin_q;

endmodule

// File: rtl/ccd_col_classify.sv
module ccd_col_classify
   import ccd_seq_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int BIN_W = 3,
   parameter int CNT_W = COL_W + 1
) (
   input  logic [CNT_W-1:0] col,
   input  logic [COL_W-1:0] cols,
   input  logic [COL_W-1:0] win_first,
   input  logic [COL_W-1:0] win_last,
   input  logic             win_ok,
   input  logic [BIN_W-1:0] hbin,
   input  logic [BIN_W-1:0] bcnt,
   output col_act_t         act
);
   if (CNT_W <= COL_W || CNT_W < BIN_W) begin : g_bad_w
      $error("ccd_col_classify: counter too narrow");
   end

   logic             in_win;
   logic [CNT_W-1:0] win_left;

   assign in_win   = win_ok && (col >= CNT_W'(win_first)) && (col <= CNT_W'(win_last));
   assign win_left = CNT_W'(win_last) - col + CNT_W'(1);

   always_comb begin
      act = '0;
      if (col >= CNT_W'(cols)) begin
         act.sample = 1'b1;                      // overscan: one shift, one sample
      end else if (in_win) begin
         if (bcnt == '0 && win_left < CNT_W'(hbin)) begin
            act.dump = 1'b1;                     // incomplete trailing group
         end else begin
            act.binned = 1'b1;
            act.sample = (bcnt + BIN_W'(1)) == hbin;
         end
      end else begin
         act.dump = 1'b1;
      end
   end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
   import ccd_seq_pkg::*;
#(
   parameter int ROW_W  = 10,
   parameter int COL_W  = 10,
   parameter int OS_W   = 6,
   parameter int BIN_W  = 3,
   parameter int STEP_W = 4,
   parameter int NPH    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ROW_W-1:0]  cfg_rows,
   input  logic [COL_W-1:0]  cfg_cols,
   input  logic [OS_W-1:0]   cfg_overscan,
   input  logic [BIN_W-1:0]  cfg_vbin,
   input  logic [BIN_W-1:0]  cfg_hbin,
   input  logic [COL_W-1:0]  cfg_win_first,
   input  logic [COL_W-1:0]  cfg_win_last,
   input  logic [STEP_W-1:0] cfg_step,
   output logic [NPH-1:0]    par_clk,
   output logic [NPH-1:0]    ser_clk,
   output logic              dump,
   output logic              smp_rst,
   output logic              smp_sig,
   output logic              adc_start,
   output logic              pix_valid,
   output logic              busy,
   output logic              done
);
   localparam int CNT_W = COL_W + 1;

   if (OS_W > COL_W) begin : g_bad_os
      $error("ccd_readout_seq: OS_W must not exceed COL_W");
   end
   if (BIN_W > ROW_W || BIN_W < 1) begin : g_bad_bin
      $error("ccd_readout_seq: BIN_W out of range");
   end

   seq_state_t        state_q;
   logic [ROW_W-1:0]  rows_q, r_q, rows_left;
   logic [COL_W-1:0]  cols_q, wfirst_q, wlast_q, wlast_clip;
   logic [OS_W-1:0]   os_q;
   logic [BIN_W-1:0]  vbin_q, hbin_q, vcnt_q, bcnt_q;
   logic [STEP_W-1:0] step_q;
   logic              win_ok_q, win_ok_in;
   logic [CNT_W-1:0]  col_q, row_len;
   logic              dump_q, samp_q;
   logic              rows_short, par_go, ser_go, par_fin, ser_fin;
   col_act_t          act;

   // window end clipped to the row, evaluated on the live inputs at capture
   assign wlast_clip = (cfg_win_last >= cfg_cols) ? cfg_cols - COL_W'(1) : cfg_win_last;
   assign win_ok_in  = (cfg_cols != '0) && (cfg_win_first <= wlast_clip);

   assign rows_left  = rows_q - r_q;
   assign rows_short = (vcnt_q == '0) && (rows_left < ROW_W'(vbin_q));
   assign row_len    = CNT_W'(cols_q) + CNT_W'(os_q);
   assign par_go     = (state_q == S_PAR_GO) && !rows_short;
   assign ser_go     = (state_q == S_SER_GO) && (col_q != row_len);

   ccd_phase_gen #(.NPH(NPH), .STEP_W(STEP_W)) i_par (
      .clk(clk), .rst_n(rst_n), .go(par_go), .step_len(step_q),
      .ph(par_clk), .fin(par_fin)
   );

   ccd_phase_gen #(.NPH(NPH), .STEP_W(STEP_W)) i_ser (
      .clk(clk), .rst_n(rst_n), .go(ser_go), .step_len(step_q),
      .ph(ser_clk), .fin(ser_fin)
   );

   ccd_col_classify #(.COL_W(COL_W), .BIN_W(BIN_W), .CNT_W(CNT_W)) i_cls (
      .col(col_q), .cols(cols_q), .win_first(wfirst_q), .win_last(wlast_q),
      .win_ok(win_ok_q), .hbin(hbin_q), .bcnt(bcnt_q), .act(act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         rows_q   <= '0;
         r_q      <= '0;
         cols_q   <= '0;
         wfirst_q <= '0;
         wlast_q  <= '0;
         win_ok_q <= 1'b0;
         os_q     <= '0;
         vbin_q   <= BIN_W'(1);
         hbin_q   <= BIN_W'(1);
         step_q   <= '0;
         vcnt_q   <= '0;
         bcnt_q   <= '0;
         col_q    <= '0;
         dump_q   <= 1'b0;
         samp_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: if (start) begin
               rows_q   <= cfg_rows;
               cols_q   <= cfg_cols;
               os_q     <= cfg_overscan;
               vbin_q   <= (cfg_vbin == '0) ? BIN_W'(1) : cfg_vbin;
               hbin_q   <= (cfg_hbin == '0) ? BIN_W'(1) : cfg_hbin;
               wfirst_q <= cfg_win_first;
               wlast_q  <= wlast_clip;
               win_ok_q <= win_ok_in;
               step_q   <= cfg_step;
               r_q      <= '0;
               vcnt_q   <= '0;
               state_q  <= S_PAR_GO;
            end
            S_PAR_GO: state_q <= rows_short ? S_DONE : S_PAR_WAIT;
            S_PAR_WAIT: if (par_fin) begin
               r_q <= r_q + ROW_W'(1);
               if ((vcnt_q + BIN_W'(1)) == vbin_q) begin
                  vcnt_q  <= '0;
                  col_q   <= '0;
                  bcnt_q  <= '0;
                  state_q <= S_SER_GO;
               end else begin
                  vcnt_q  <= vcnt_q + BIN_W'(1);
                  state_q <= S_PAR_GO;
               end
            end
            S_SER_GO: begin
               if (col_q == row_len) begin
                  state_q <= S_PAR_GO;
               end else begin
                  dump_q <= act.dump;
                  samp_q <= act.sample;
                  if (act.binned) begin
                     bcnt_q <= act.sample ? '0 : bcnt_q + BIN_W'(1);
                  end
                  state_q <= S_SER_WAIT;
               end
            end
            S_SER_WAIT: if (ser_fin) begin
               dump_q  <= 1'b0;
               col_q   <= col_q + CNT_W'(1);
               state_q <= samp_q ? S_SHR : S_SER_GO;
            end
            S_SHR:   state_q <= S_SHS;
            S_SHS:   state_q <= S_CONV;
            S_CONV:  state_q <= S_SER_GO;
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign dump      = dump_q;
   assign smp_rst   = (state_q == S_SHR);
   assign smp_sig   = (state_q == S_SHS);
   assign adc_start = (state_q == S_CONV);
   assign pix_valid = (state_q == S_CONV);
   assign busy      = (state_q != S_IDLE);
   assign done      = (state_q == S_DONE);

endmodule

// File: rtl/ccd_seq_checker.sv
module ccd_seq_checker #(
   parameter int NPH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [NPH-1:0] par_clk,
   input logic [NPH-1:0] ser_clk,
   input logic           dump,
   input logic           smp_rst,
   input logic           smp_sig,
   input logic           adc_start,
   input logic           pix_valid,
   input logic           busy,
   input logic           done
);
   p_phase_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(par_clk) && $onehot0(ser_clk));

   p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !((|par_clk) && (|ser_clk)));

   for (genvar k = 1; k < NPH; k++) begin : g_order
      p_par_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(par_clk[k]) |-> $past(par_clk[k-1]));
      p_ser_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ser_clk[k]) |-> $past(ser_clk[k-1]));
   end

   p_dump_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dump |-> !(smp_rst || smp_sig || adc_start || pix_valid));

   p_sig_after_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_rst |=> smp_sig);

   p_conv_after_sig_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_sig |=> (adc_start && pix_valid));

   p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> !pix_valid);

   p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (par_clk == '0 && ser_clk == '0 && !dump && !pix_valid));

endmodule

bind ccd_readout_seq ccd_seq_checker #(.NPH(NPH)) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .par_clk(par_clk), .ser_clk(ser_clk),
   .dump(dump), .smp_rst(smp_rst), .smp_sig(smp_sig), .adc_start(adc_start),
   .pix_valid(pix_valid), .busy(busy), .done(done)
);

// File: tb/test_ccd_readout_seq.sv
module test_ccd_readout_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [9:0] cfg_rows = '0, cfg_cols = '0, cfg_win_first = '0, cfg_win_last = '0;
   logic [5:0] cfg_overscan = '0;
   logic [2:0] cfg_vbin = '0, cfg_hbin = '0;
   logic [3:0] cfg_step = '0;
   logic [2:0] par_clk, ser_clk;
   logic       dump, smp_rst, smp_sig, adc_start, pix_valid, busy, done;

   int n_chk = 0;
   int n_fail = 0;
   int gcyc = 0;

   always #2 clk = ~clk;   // 250 MHz

   ccd_readout_seq i_ccd_readout_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
      .cfg_overscan(cfg_overscan), .cfg_vbin(cfg_vbin), .cfg_hbin(cfg_hbin),
      .cfg_win_first(cfg_win_first), .cfg_win_last(cfg_win_last), .cfg_step(cfg_step),
      .par_clk(par_clk), .ser_clk(ser_clk), .dump(dump), .smp_rst(smp_rst),
      .smp_sig(smp_sig), .adc_start(adc_start), .pix_valid(pix_valid),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      gcyc++;
      if (gcyc > 195000) begin
         chk(1'b0, "R10 global watchdog", gcyc, 195000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic run_cfg(input int rows, input int cols, input int os, input int vb,
                          input int hb, input int wf, input int wl, input int st,
                          input bit poke);
      int vbe, hbe, ste, wle, w, keep_end, groups, ngw, cyc;
      int par_tot, ser_tot, dump_tot, pv_tot, shr_tot, burst, col_k, run_len;
      bit in_row, p_par0, p_ser0, p_shr, p_shs, exp_d, fin;
      string tag;
      vbe = (vb == 0) ? 1 : vb;
      hbe = (hb == 0) ? 1 : hb;
      ste = (st == 0) ? 1 : st;
      wle = (wl >= cols) ? cols - 1 : wl;
      w = (cols > 0 && wf <= wle) ? wle - wf + 1 : 0;
      ngw = w / hbe;
      keep_end = wf + ngw * hbe - 1;
      groups = rows / vbe;
      par_tot = 0; ser_tot = 0; dump_tot = 0; pv_tot = 0; shr_tot = 0;
      burst = 0; col_k = 0; run_len = 0; cyc = 0;
      in_row = 0; p_par0 = 0; p_ser0 = 0; p_shr = 0; p_shs = 0; fin = 0;

      @(negedge clk);
      cfg_rows = 10'(rows); cfg_cols = 10'(cols); cfg_overscan = 6'(os);
      cfg_vbin = 3'(vb); cfg_hbin = 3'(hb); cfg_win_first = 10'(wf);
      cfg_win_last = 10'(wl); cfg_step = 4'(st); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R1 busy after start", busy, 1);
      while (!fin) begin
         if (poke && cyc == 30) begin
            // R1: new start and new configuration mid-readout must be ignored
            start = 1'b1; cfg_rows = 10'd9; cfg_cols = 10'd2; cfg_overscan = 6'd5;
            cfg_vbin = 3'd1; cfg_hbin = 3'd1; cfg_win_first = 10'd0; cfg_win_last = 10'd1;
         end else begin
            start = 1'b0;
         end
         if (par_clk != 0 && ser_clk != 0) chk(1'b0, "R3 overlap", 1, 0);
         if (par_clk[0] && !p_par0) begin
            if (in_row) begin
               chk(col_k == cols + os, "R4 shifts per row", col_k, cols + os);
               in_row = 0; burst = 0;
            end
            burst++; par_tot++;
         end
         if (ser_clk[0] && !p_ser0) begin
            if (!in_row) begin
               chk(burst == vbe, "R2 parallel burst", burst, vbe);
               in_row = 1; col_k = 0;
            end
            exp_d = (col_k < cols) && !(w > 0 && col_k >= wf && col_k <= keep_end);
            if (col_k >= cols) tag = "R8 overscan dump";
            else if (w > 0 && col_k >= wf && col_k <= wle) tag = "R7 window dump";
            else if (wl >= cols) tag = "R6 clipped dump";
            else tag = "R5 outside dump";
            chk(dump == exp_d, tag, dump, exp_d);
            if (dump) dump_tot++;
            col_k++; ser_tot++;
         end
         if (ser_clk[0]) run_len++;
         else if (p_ser0) begin
            chk(run_len == ste, "R3 step length", run_len, ste);
            run_len = 0;
         end
         if (smp_rst) shr_tot++;
         if (smp_sig) chk(p_shr, "R9 sig after rst", p_shr, 1);
         if (adc_start) chk(p_shs && pix_valid, "R9 conv after sig", pix_valid, 1);
         if (pix_valid) pv_tot++;
         p_par0 = par_clk[0]; p_ser0 = ser_clk[0]; p_shr = smp_rst; p_shs = smp_sig;
         if (done) fin = 1;
         cyc++;
         if (cyc > 20000) begin
            chk(1'b0, "R10 run watchdog", cyc, 20000);
            fin = 1;
         end
         if (!fin) @(negedge clk);
      end
      start = 1'b0;
      if (in_row) chk(col_k == cols + os, "R4 shifts last row", col_k, cols + os);
      chk(par_tot == groups * vbe, "R2 parallel total", par_tot, groups * vbe);
      chk(ser_tot == groups * (cols + os), "R4 serial total", ser_tot, groups * (cols + os));
      chk(dump_tot == groups * (cols - ngw * hbe), "R7 dump total", dump_tot,
          groups * (cols - ngw * hbe));
      chk(shr_tot == groups * (ngw + os), "R9 sample total", shr_tot, groups * (ngw + os));
      chk(pv_tot == groups * (ngw + os), "R10 pixel total", pv_tot, groups * (ngw + os));
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R10 end of readout", {busy, done}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(par_clk == 0 && ser_clk == 0 && !dump && !busy && !done && !pix_valid,
          "R1 reset state", {par_clk, ser_clk}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // sweep over a six-column frame
      for (int vb = 1; vb <= 3; vb++)
         for (int hb = 1; hb <= 3; hb++)
            for (int wf = 0; wf <= 3; wf += (wf == 1) ? 2 : 1)
               for (int wi = 0; wi < 4; wi++)
                  for (int os = 0; os <= 2; os += 2)
                     run_cfg(4, 6, os, vb, hb, wf, (wi == 0) ? 2 : (wi == 1) ? 4 :
                             (wi == 2) ? 5 : 9, 1, 1'b0);
      run_cfg(3, 5, 1, 0, 0, 1, 3, 2, 1'b0);   // bin 0 treated as 1 (R2, R7)
      run_cfg(2, 6, 1, 1, 2, 4, 2, 1, 1'b0);   // empty window (R6)
      run_cfg(0, 6, 2, 1, 1, 0, 5, 1, 1'b0);   // no rows (R10)
      run_cfg(2, 7, 0, 2, 3, 1, 30, 3, 1'b0);  // clipped, long step (R6, R3)
      run_cfg(3, 6, 1, 1, 2, 1, 4, 0, 1'b0);   // step 0 treated as 1 (R3)
      run_cfg(5, 6, 2, 2, 2, 0, 5, 2, 1'b1);   // mid-run start ignored (R1)
      run_cfg(1, 4, 0, 1, 1, 0, 3, 1, 1'b0);   // accepted again after done (R1)
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule